// File: doc/BRIEF.md
# Vertex Matrix Transform Unit

This unit sits between a vertex fetcher and a rasterizer. It holds a 4x4 model-view-projection matrix in sixteen registers and takes vertices one at a time. Each vertex has a position (x, y, z) in signed 16.16 fixed point and a color tag. The unit multiplies the homogeneous position (x, y, z, 1.0) by the matrix. It then divides the clip-space x, y and z by the clip-space w. Finally it maps the normalised x and y onto a pixel grid. The color goes through unchanged. A vertex with w at or below zero is marked as behind the viewer and gets zeroed coordinates.

All arithmetic runs through one non-pipelined multiplier and one serial divider, so each cycle holds at most one multiply-add or one subtract step. The sixteen matrix products come first, then three divisions and then two scaling multiplies. The source side gets a stall flag while a vertex is in flight. The destination side sees a valid flag, which is held until its own stall input drops.

The controller has these states:
- `ST_IDLE`: waits for a vertex.
- `ST_MAC_GO` and `ST_MAC_WAIT`: issue and wait for each matrix product.
- `ST_DIV_GO` and `ST_DIV_WAIT`: issue and wait for each perspective division.
- `ST_SCL_GO` and `ST_SCL_WAIT`: issue and wait for the two pixel scalings.
- `ST_EMIT`: presents the result.

The transitions are:
- `ST_IDLE` to `ST_MAC_GO` on `i_valid`.
- `ST_MAC_GO` to `ST_MAC_WAIT` always.
- `ST_MAC_WAIT` back to `ST_MAC_GO` after each product except the sixteenth.
- After the sixteenth product, `ST_MAC_WAIT` goes to `ST_DIV_GO` if w > 0, and to `ST_EMIT` otherwise.
- `ST_DIV_GO` to `ST_DIV_WAIT` always.
- `ST_DIV_WAIT` back to `ST_DIV_GO` for the next axis, or to `ST_SCL_GO` after z.
- `ST_SCL_GO` to `ST_SCL_WAIT` always.
- `ST_SCL_WAIT` back to `ST_SCL_GO` after x, or to `ST_EMIT` after y.
- `ST_EMIT` to `ST_IDLE` when `i_stall` is low.

Top module: `vxf_transform`

## Requirements
- R1: After reset `o_valid` is 0 and `o_in_stall` is 0. The matrix holds identity: entries 0, 5, 10 and 15 are 1.0 (0x0001_0000) and the rest are 0.
- R2: Matrix entry index = row*4 + column. A write (`i_mat_we`, `i_mat_idx`, `i_mat_data`) takes effect in a cycle where `o_in_stall` is 0. A vertex accepted in that same cycle uses the new value. A write in a cycle where `o_in_stall` is 1 is discarded.
- R3: Clip row r = sum over c of M[r*4+c]·v[c], with v = (x, y, z, 1.0). Each product is (a·b + 2^15) arithmetically shifted right by 16 and truncated to 32 bits. The sums wrap at 32 bits.
- R4: When w > 0, each normalised value is trunc(|c|·2^16 / w) with the sign of c. The magnitude saturates at 2^31−1. `o_z` is the normalised z.
- R5: Normalised x and y are clamped to [−1.0, 1.0]. Then `o_x` = floor((nx+1)·SCR_W/2) and `o_y` = floor((1−ny)·SCR_H/2). A result equal to SCR_W or SCR_H becomes SCR_W−1 or SCR_H−1.
- R6: When clip w ≤ 0, `o_behind` = 1 and `o_x`, `o_y` and `o_z` are 0. Otherwise `o_behind` = 0.
- R7: `o_color` equals the color of the vertex being presented.
- R8: A vertex is accepted on a rising edge where `i_valid` = 1 and `o_in_stall` = 0. `o_in_stall` is 1 from the next cycle until the result is taken. An `i_valid` raised while `o_in_stall` = 1 is ignored and produces no output.
- R9: While `o_valid` = 1 and `i_stall` = 1, `o_valid` stays 1 and all outputs hold. The result is taken on an edge with `o_valid` = 1 and `i_stall` = 0, and `o_valid` is 0 in the next cycle.
- R10: One multiply is in flight at a time, each taking MUL_LAT cycles. The cycle count from acceptance to `o_valid` is the same for every vertex with w > 0, and shorter for a vertex with w ≤ 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_mat_we | input | 1 | Matrix entry write strobe |
| i_mat_idx | input | 4 | Matrix entry index (row*4+column) |
| i_mat_data | input | 32 | Matrix entry value, 16.16 |
| i_valid | input | 1 | Vertex offered by the fetcher |
| i_x | input | 32 | Vertex x, 16.16 |
| i_y | input | 32 | Vertex y, 16.16 |
| i_z | input | 32 | Vertex z, 16.16 |
| i_color | input | COLOR_W | Vertex color tag |
| o_in_stall | output | 1 | Unit busy; fetcher must hold off |
| o_valid | output | 1 | Transformed vertex presented |
| o_x | output | $clog2(SCR_W) | Pixel column |
| o_y | output | $clog2(SCR_H) | Pixel row |
| o_z | output | 32 | Normalised depth, 16.16 |
| o_color | output | COLOR_W | Forwarded color tag |
| o_behind | output | 1 | Clip w was zero or negative |
| i_stall | input | 1 | Next stage cannot take the vertex |

## Verification
The bench builds the unit with MUL_LAT = 4, the slowest multiplier allowed, and with the default 640 by 480 grid and 24-bit color. The long multiplier latency widens the window in which matrix writes and extra vertex offers can land mid-transform. It also makes the latency comparison between visible and behind vertices clear-cut. The grid size puts the clamped corners at columns 0 and 639 and rows 0 and 479. Perspective and mixed-sign matrices exercise rounding of negative products and saturation of the divider quotient.

// File: rtl/vxf_pkg.sv
package vxf_pkg;

    localparam int FX_W    = 32;
    localparam int FX_FRAC = 16;
    localparam int MAT_N   = 16;

    typedef logic signed [FX_W-1:0] fx_t;

    localparam fx_t FX_ONE = fx_t'(1) <<< FX_FRAC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC_GO,
        ST_MAC_WAIT,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_SCL_GO,
        ST_SCL_WAIT,
        ST_EMIT
    } vxf_state_e;

    function automatic fx_t fx_clamp_unit(input fx_t v);
        if (v > FX_ONE)
            return FX_ONE;
        else if (v < -FX_ONE)
            return -FX_ONE;
        else
            return v;
    endfunction

endpackage

// File: rtl/vxf_matrix_regs.sv
module vxf_matrix_regs
    import vxf_pkg::*;
#(
    parameter int N     = MAT_N,
    parameter int DIM   = 4,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_we,
    input  logic [IDXW-1:0] i_idx,
    input  fx_t             i_data,
    output fx_t [N-1:0]     o_mat
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_entry
            localparam fx_t RST_VAL = ((g % (DIM + 1)) == 0) ? FX_ONE : '0;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    o_mat[g] <= RST_VAL;
                else if (i_we && (i_idx == IDXW'(g)))
                    o_mat[g] <= i_data;
            end
        end
    endgenerate

endmodule

// File: rtl/vxf_mul.sv
module vxf_mul
    import vxf_pkg::*;
#(
    parameter int LAT    = 3,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i_start,
    input  fx_t  i_a,
    input  fx_t  i_b,
    output logic o_busy,
    output logic o_done,
    output fx_t  o_p
);

    fx_t               a_q;
    fx_t               b_q;
    logic [CNT_W-1:0]  cnt;
    logic signed [2*FX_W-1:0] prod;
    logic signed [2*FX_W-1:0] prod_rnd;

    always_comb begin
        prod     = $signed({{FX_W{a_q[FX_W-1]}}, a_q}) * $signed({{FX_W{b_q[FX_W-1]}}, b_q});
        prod_rnd = prod + (2*FX_W)'(64'sd1 <<< (FX_FRAC - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_busy <= 1'b0;
            o_done <= 1'b0;
            cnt    <= '0;
            a_q    <= '0;
            b_q    <= '0;
            o_p    <= '0;
        end else begin
            o_done <= 1'b0;
            if (i_start && !o_busy) begin
                a_q    <= i_a;
                b_q    <= i_b;
                cnt    <= CNT_W'(LAT - 1);
                o_busy <= 1'b1;
            end else if (o_busy) begin
                if (cnt == '0) begin
                    o_busy <= 1'b0;
                    o_done <= 1'b1;
                    o_p    <= prod_rnd[FX_FRAC +: FX_W];
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_MUL_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        i_start |-> !o_busy && !o_done); // R10

endmodule

// File: rtl/vxf_div.sv
module vxf_div
    import vxf_pkg::*;
#(
    parameter int NUM_W  = FX_W,
    parameter int FRAC   = FX_FRAC,
    localparam int DW    = NUM_W + FRAC,
    localparam int CNT_W = $clog2(DW + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_start,
    input  logic signed [NUM_W-1:0] i_num,
    input  logic signed [NUM_W-1:0] i_den,
    output logic                    o_done,
    output logic signed [NUM_W-1:0] o_q
);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    dvd;
    logic [DW-1:0]    quo;
    logic [NUM_W:0]   rem;
    logic [NUM_W-1:0] den_q;
    logic             neg;
    logic [NUM_W-1:0] mag;
    logic [NUM_W:0]   rem_sh;
    logic [NUM_W-2:0] sat;

    always_comb begin
        mag    = i_num[NUM_W-1] ? NUM_W'(-i_num) : NUM_W'(i_num);
        rem_sh = {rem[NUM_W-1:0], dvd[DW-1]};
        sat    = (|quo[DW-1:NUM_W-1]) ? {(NUM_W-1){1'b1}} : quo[NUM_W-2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            dvd    <= '0;
            quo    <= '0;
            rem    <= '0;
            den_q  <= '0;
            neg    <= 1'b0;
            o_done <= 1'b0;
            o_q    <= '0;
        end else begin
            o_done <= 1'b0;
            if (i_start && !busy) begin
                busy  <= 1'b1;
                cnt   <= CNT_W'(DW);
                dvd   <= {mag, {FRAC{1'b0}}};
                quo   <= '0;
                rem   <= '0;
                den_q <= i_den;
                neg   <= i_num[NUM_W-1];
            end else if (busy) begin
                if (cnt == '0) begin
                    busy   <= 1'b0;
                    o_done <= 1'b1;
                    o_q    <= neg ? -$signed({1'b0, sat}) : $signed({1'b0, sat});
                end else begin
                    cnt <= cnt - 1'b1;
                    dvd <= dvd << 1;
                    if (rem_sh >= {1'b0, den_q}) begin
                        rem <= rem_sh - {1'b0, den_q};
                        quo <= {quo[DW-2:0], 1'b1};
                    end else begin
                        rem <= rem_sh;
                        quo <= {quo[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_DIV_DEN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        i_start |-> i_den > 0 && !busy); // R4

endmodule

// File: rtl/vxf_transform.sv
module vxf_transform
    import vxf_pkg::*;
#(
    parameter int SCR_W   = 640,
    parameter int SCR_H   = 480,
    parameter int COLOR_W = 24,
    parameter int MUL_LAT = 3,
    localparam int XW     = $clog2(SCR_W),
    localparam int YW     = $clog2(SCR_H),
    localparam int IDXW   = $clog2(MAT_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_mat_we,
    input  logic [IDXW-1:0]     i_mat_idx,
    input  logic signed [31:0]  i_mat_data,
    input  logic                i_valid,
    input  logic signed [31:0]  i_x,
    input  logic signed [31:0]  i_y,
    input  logic signed [31:0]  i_z,
    input  logic [COLOR_W-1:0]  i_color,
    output logic                o_in_stall,
    output logic                o_valid,
    output logic [XW-1:0]       o_x,
    output logic [YW-1:0]       o_y,
    output logic signed [31:0]  o_z,
    output logic [COLOR_W-1:0]  o_color,
    output logic                o_behind,
    input  logic                i_stall
);

    localparam fx_t HALF_W_FX = fx_t'((SCR_W / 2) << FX_FRAC);
    localparam fx_t HALF_H_FX = fx_t'((SCR_H / 2) << FX_FRAC);

    vxf_state_e state, state_nx;

    fx_t [MAT_N-1:0] mat_q;
    fx_t             vx, vy, vz;
    fx_t             acc;
    fx_t [3:0]       clip;
    fx_t [2:0]       ndc;
    logic [1:0]      row, col, dsel;
    logic            ssel;

    logic  mat_we;
    logic  mul_start, mul_busy, mul_done;
    fx_t   mul_a, mul_b, mul_p;
    logic  div_start, div_done;
    fx_t   div_q;
    fx_t   vcomp;
    fx_t   acc_sum;
    logic  mac_last;
    logic [FX_W-FX_FRAC-1:0] pix_int;

    assign mat_we = i_mat_we && (state == ST_IDLE);

    vxf_matrix_regs #(.N(MAT_N), .DIM(4)) u_mat (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_we   (mat_we),
        .i_idx  (i_mat_idx),
        .i_data (i_mat_data),
        .o_mat  (mat_q)
    );

    vxf_mul #(.LAT(MUL_LAT)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_start (mul_start),
        .i_a     (mul_a),
        .i_b     (mul_b),
        .o_busy  (mul_busy),
        .o_done  (mul_done),
        .o_p     (mul_p)
    );

    vxf_div #(.NUM_W(FX_W), .FRAC(FX_FRAC)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_start (div_start),
        .i_num   (clip[dsel]),
        .i_den   (clip[3]),
        .o_done  (div_done),
        .o_q     (div_q)
    );

    // operand selection for the shared multiplier
    always_comb begin
        unique case (col)
            2'd0: vcomp = vx;
            2'd1: vcomp = vy;
            2'd2: vcomp = vz;
            default: vcomp = FX_ONE;
        endcase
        acc_sum  = acc + mul_p;
        mac_last = (row == 2'd3) && (col == 2'd3);
        pix_int  = mul_p[FX_W-1:FX_FRAC];
        if (state == ST_SCL_GO) begin
            mul_a = ssel ? (FX_ONE - ndc[1]) : (ndc[0] + FX_ONE);
            mul_b = ssel ? HALF_H_FX : HALF_W_FX;
        end else begin
            mul_a = mat_q[{row, col}];
            mul_b = vcomp;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and control outputs
    always_comb begin
        state_nx   = state;
        mul_start  = 1'b0;
        div_start  = 1'b0;
        o_in_stall = (state != ST_IDLE);
        o_valid    = (state == ST_EMIT);
        unique case (state)
            ST_IDLE:     if (i_valid) state_nx = ST_MAC_GO;
            ST_MAC_GO: begin
                mul_start = 1'b1;
                state_nx  = ST_MAC_WAIT;
            end
            ST_MAC_WAIT: begin
                if (mul_done) begin
                    if (!mac_last)
                        state_nx = ST_MAC_GO;
                    else if (acc_sum > 0)
                        state_nx = ST_DIV_GO;
                    else
                        state_nx = ST_EMIT;
                end
            end
            ST_DIV_GO: begin
                div_start = 1'b1;
                state_nx  = ST_DIV_WAIT;
            end
            ST_DIV_WAIT: begin
                if (div_done)
                    state_nx = (dsel == 2'd2) ? ST_SCL_GO : ST_DIV_GO;
            end
            ST_SCL_GO: begin
                mul_start = 1'b1;
                state_nx  = ST_SCL_WAIT;
            end
            ST_SCL_WAIT: begin
                if (mul_done)
                    state_nx = ssel ? ST_EMIT : ST_SCL_GO;
            end
            ST_EMIT:     if (!i_stall) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vx       <= '0;
            vy       <= '0;
            vz       <= '0;
            o_color  <= '0;
            acc      <= '0;
            clip     <= '0;
            ndc      <= '0;
            row      <= '0;
            col      <= '0;
            dsel     <= '0;
            ssel     <= 1'b0;
            o_x      <= '0;
            o_y      <= '0;
            o_z      <= '0;
            o_behind <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (i_valid) begin
                        vx      <= i_x;
                        vy      <= i_y;
                        vz      <= i_z;
                        o_color <= i_color;
                        acc     <= '0;
                        row     <= '0;
                        col     <= '0;
                        dsel    <= '0;
                        ssel    <= 1'b0;
                    end
                end
                ST_MAC_WAIT: begin
                    if (mul_done) begin
                        col <= col + 2'd1;
                        if (col == 2'd3) begin
                            clip[row] <= acc_sum;
                            acc       <= '0;
                            row       <= row + 2'd1;
                            if (mac_last && !(acc_sum > 0)) begin
                                o_x      <= '0;
                                o_y      <= '0;
                                o_z      <= '0;
                                o_behind <= 1'b1;
                            end
                        end else begin
                            acc <= acc_sum;
                        end
                    end
                end
                ST_DIV_WAIT: begin
                    if (div_done) begin
                        ndc[dsel] <= (dsel == 2'd2) ? div_q : fx_clamp_unit(div_q);
                        dsel      <= dsel + 2'd1;
                    end
                end
                ST_SCL_WAIT: begin
                    if (mul_done) begin
                        ssel <= 1'b1;
                        if (!ssel) begin
                            o_x <= (pix_int >= (FX_W-FX_FRAC)'(SCR_W)) ? XW'(SCR_W - 1)
                                                                       : pix_int[XW-1:0];
                        end else begin
                            o_y      <= (pix_int >= (FX_W-FX_FRAC)'(SCR_H)) ? YW'(SCR_H - 1)
                                                                            : pix_int[YW-1:0];
                            o_z      <= ndc[2];
                            o_behind <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && i_stall |=> o_valid && $stable(o_x) && $stable(o_y) && $stable(o_z)
                               && $stable(o_behind) && $stable(o_color)); // R9
    AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !i_stall |=> !o_valid); // R9
    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (int'(o_x) < SCR_W) && (int'(o_y) < SCR_H)); // R5
    AST_BEHIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && o_behind |-> (o_x == '0) && (o_y == '0) && (o_z == '0)); // R6
    AST_MAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        o_in_stall |=> $stable(mat_q)); // R2
    AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        o_in_stall |=> $stable(o_color)); // R7
    AST_ONE_UNIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mul_busy |-> !div_start); // R10

endmodule

// File: tb/test_vxf_transform.sv
`timescale 1ns/1ps
module test_vxf_transform;

    localparam int  SW = 640;
    localparam int  SH = 480;
    localparam int  CWD = 24;
    localparam longint ONE = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_mat_we = 1'b0;
    logic [3:0] i_mat_idx = '0;
    logic signed [31:0] i_mat_data = '0;
    logic i_valid = 1'b0;
    logic signed [31:0] i_x = '0, i_y = '0, i_z = '0;
    logic [CWD-1:0] i_color = '0;
    logic i_stall = 1'b0;
    logic o_in_stall, o_valid, o_behind;
    logic [9:0] o_x;
    logic [8:0] o_y;
    logic signed [31:0] o_z;
    logic [CWD-1:0] o_color;

    int n_tests = 0;
    int n_fail = 0;
    bit done_flag = 0;
    longint m[16];

    always #2.5 clk = ~clk;

    vxf_transform #(.SCR_W(SW), .SCR_H(SH), .COLOR_W(CWD), .MUL_LAT(4)) i_vxf_transform (
        .clk(clk), .rst_n(rst_n), .i_mat_we(i_mat_we), .i_mat_idx(i_mat_idx),
        .i_mat_data(i_mat_data), .i_valid(i_valid), .i_x(i_x), .i_y(i_y), .i_z(i_z),
        .i_color(i_color), .o_in_stall(o_in_stall), .o_valid(o_valid), .o_x(o_x),
        .o_y(o_y), .o_z(o_z), .o_color(o_color), .o_behind(o_behind), .i_stall(i_stall)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint s32(input longint v);
        logic signed [31:0] t;
        t = v[31:0];
        return longint'(t);
    endfunction

    function automatic longint fxmul(input longint a, input longint b);
        return s32((a * b + 32768) >>> 16);
    endfunction

    function automatic longint fxdiv(input longint n, input longint d);
        longint mg, q;
        mg = (n < 0) ? -n : n;
        q = (mg <<< 16) / d;
        if (q > 64'd2147483647) q = 2147483647;
        return (n < 0) ? -q : q;
    endfunction

    function automatic longint clampu(input longint v);
        if (v > ONE) return ONE;
        if (v < -ONE) return -ONE;
        return v;
    endfunction

    task automatic model(input longint x, input longint y, input longint z,
                         output longint ex, output longint ey, output longint ez,
                         output longint eb);
        longint c[4];
        longint v[4];
        longint acc, nx, ny, px, py;
        v[0] = x; v[1] = y; v[2] = z; v[3] = ONE;
        for (int r = 0; r < 4; r++) begin
            acc = 0;
            for (int k = 0; k < 4; k++) acc = s32(acc + fxmul(m[r*4+k], v[k]));
            c[r] = acc;
        end
        if (c[3] <= 0) begin
            ex = 0; ey = 0; ez = 0; eb = 1;
        end else begin
            nx = clampu(fxdiv(c[0], c[3]));
            ny = clampu(fxdiv(c[1], c[3]));
            ez = fxdiv(c[2], c[3]);
            px = ((nx + ONE) * (SW / 2)) >>> 16;
            py = ((ONE - ny) * (SH / 2)) >>> 16;
            ex = (px >= SW) ? SW - 1 : px;
            ey = (py >= SH) ? SH - 1 : py;
            eb = 0;
        end
    endtask

    task automatic wr_mat(input int idx, input longint val);
        @(negedge clk);
        i_mat_we = 1'b1; i_mat_idx = 4'(idx); i_mat_data = val[31:0];
        @(negedge clk);
        i_mat_we = 1'b0;
        m[idx] = val;
    endtask

    task automatic load_ident();
        for (int k = 0; k < 16; k++) wr_mat(k, (k % 5 == 0) ? ONE : 0);
    endtask

    task automatic send(input longint x, input longint y, input longint z,
                        input logic [CWD-1:0] col);
        @(negedge clk);
        i_valid = 1'b1; i_x = x[31:0]; i_y = y[31:0]; i_z = z[31:0]; i_color = col;
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    task automatic wait_out(output int lat);
        lat = 1;
        while (!o_valid && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vertex(input string req, input longint x, input longint y,
                              input longint z, input logic [CWD-1:0] col, output int lat);
        longint ex, ey, ez, eb;
        model(x, y, z, ex, ey, ez, eb);
        send(x, y, z, col);
        wait_out(lat);
        chk({req, " valid"}, longint'(o_valid), 1);
        chk({req, " x"}, longint'(o_x), ex);
        chk({req, " y"}, longint'(o_y), ey);
        chk({req, " z"}, longint'(o_z), ez);
        chk({req, " behind R6"}, longint'(o_behind), eb);
        chk({req, " color R7"}, longint'(o_color), longint'(col));
        @(negedge clk);
    endtask

    task automatic t_reset();
        int lat;
        chk("R1 valid after reset", longint'(o_valid), 0);
        chk("R1 in_stall after reset", longint'(o_in_stall), 0);
        for (int k = 0; k < 16; k++) m[k] = (k % 5 == 0) ? ONE : 0;
        run_vertex("R1 identity", 32768, -16384, 49152, 24'hABCDEF, lat);
        chk("R1 identity px", longint'(o_x), 480);
    endtask

    task automatic t_edges();
        int lat;
        load_ident();
        run_vertex("R5 corner hi", ONE, ONE, 32768, 24'h000001, lat);
        run_vertex("R5 corner lo", -ONE, -ONE, 0, 24'h000002, lat);
        run_vertex("R5 clamp", 3 * ONE, -5 * ONE, 0, 24'h000003, lat);
        run_vertex("R5 centre", 0, 0, 0, 24'h000004, lat);
    endtask

    task automatic t_persp();
        int lat;
        load_ident();
        wr_mat(15, 0);
        wr_mat(14, ONE);
        run_vertex("R4 persp a", ONE, 32768, 2 * ONE, 24'h111111, lat);
        run_vertex("R4 persp b", -3 * ONE, 5 * ONE, 7 * ONE + 123, 24'h222222, lat);
        wr_mat(8, 32'h7FFF0000);
        wr_mat(10, 32'h7FFF0000);
        run_vertex("R4 saturate", 1, 0, 1, 24'h333333, lat);
        chk("R4 saturated z", longint'(o_z), 2147483647);
    endtask

    task automatic t_general();
        int lat;
        longint vals[16] = '{98304, -40000, 12345, 70000, -65536, 33333, -77777, 1000,
                              5000, 20000, 131072, -98304, 1234, -2345, 30000, 150000};
        for (int k = 0; k < 16; k++) wr_mat(k, vals[k]);
        run_vertex("R3 general a", 12345, -54321, 99999, 24'h0F0F0F, lat);
        run_vertex("R3 general b", -200000, 150000, -33333, 24'hF0F0F0, lat);
        run_vertex("R3 general c", 7, -7, 65535, 24'h5A5A5A, lat);
    endtask

    task automatic t_behind();
        int lat;
        load_ident();
        wr_mat(15, 0);
        run_vertex("R6 w zero", ONE, ONE, ONE, 24'h777777, lat);
        wr_mat(15, -ONE);
        run_vertex("R6 w negative", 1000, 2000, 3000, 24'h888888, lat);
    endtask

    task automatic t_stall();
        int lat;
        longint ex, ey, ez, eb, sx, sy, sz;
        load_ident();
        model(16384, -16384, 8192, ex, ey, ez, eb);
        i_stall = 1'b1;
        send(16384, -16384, 8192, 24'hC0FFEE);
        repeat (5) @(negedge clk);
        i_valid = 1'b1; i_x = 32'sd0; i_y = 32'sd0; i_z = 32'sd0; i_color = 24'h123456;
        chk("R8 stall while busy", longint'(o_in_stall), 1);
        @(negedge clk);
        i_valid = 1'b0;
        wait_out(lat);
        sx = longint'(o_x); sy = longint'(o_y); sz = longint'(o_z);
        repeat (8) @(negedge clk);
        chk("R9 held valid", longint'(o_valid), 1);
        chk("R9 held x", longint'(o_x), sx);
        chk("R9 held y", longint'(o_y), sy);
        chk("R9 held z", longint'(o_z), sz);
        chk("R9 result x", longint'(o_x), ex);
        chk("R9 result y", longint'(o_y), ey);
        i_valid = 1'b1; i_color = 24'h654321;
        @(negedge clk);
        i_valid = 1'b0;
        chk("R9 color held", longint'(o_color), longint'(24'hC0FFEE));
        i_stall = 1'b0;
        @(negedge clk);
        chk("R9 valid drops after take", longint'(o_valid), 0);
        repeat (200) @(negedge clk);
        chk("R8 ignored offer gives no output", longint'(o_valid), 0);
        chk("R8 idle after ignored offer", longint'(o_in_stall), 0);
        run_vertex("R8 next vertex", -16384, 16384, 0, 24'h0000AA, lat);
    endtask

    task automatic t_matwrite();
        int lat;
        longint ex, ey, ez, eb;
        load_ident();
        model(16384, 0, 0, ex, ey, ez, eb);
        send(16384, 0, 0, 24'h000010);
        repeat (3) @(negedge clk);
        i_mat_we = 1'b1; i_mat_idx = 4'd0; i_mat_data = 32'sd131072;
        @(negedge clk);
        i_mat_we = 1'b0;
        wait_out(lat);
        chk("R2 busy write not used", longint'(o_x), ex);
        @(negedge clk);
        run_vertex("R2 busy write discarded", 16384, 0, 0, 24'h000011, lat);
        chk("R2 discarded px", longint'(o_x), 400);
        wr_mat(0, 131072);
        run_vertex("R2 idle write applied", 16384, 0, 0, 24'h000012, lat);
        chk("R2 applied px", longint'(o_x), 480);
    endtask

    task automatic t_latency();
        int la, lb, lc;
        load_ident();
        run_vertex("R10 lat a", 0, 0, 0, 24'h1, la);
        run_vertex("R10 lat b", -123456, 98765, 4321, 24'h2, lb);
        chk("R10 equal latency", longint'(lb), longint'(la));
        wr_mat(15, 0);
        run_vertex("R10 lat behind", 5, 5, 5, 24'h3, lc);
        chk("R10 behind shorter", longint'(lc < la), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edges();
        t_persp();
        t_general();
        t_behind();
        t_stall();
        t_matwrite();
        t_latency();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule